// File: doc/BRIEF.md
# Chained Tag-Driven Transmit DMA

This block is the sending half of a two-sided transfer channel. Software leaves a chain of 16-byte descriptors in memory and pulses `start` with the byte address of the first descriptor. For each descriptor, the engine reads all four words. It passes the last two words into an outbound word FIFO as the header the far side will use. It then streams the descriptor's payload words from memory into the FIFO. If the payload does not fill a whole 16-byte group, zero filler words complete it. When the descriptor that carried a termination flag has been fully sent, the engine waits a delay that tracks the amount of payload moved, then drops `busy` and pulses `irq`.

The memory side is a read request with a valid/ready handshake. `rd_valid` holds `rd_addr` steady until `rd_ready` is seen high at a clock edge, and `rd_data` is taken in that same cycle. The FIFO side follows the stream rule that a word is accepted on every cycle `push_valid` is high. Back-pressure reaches the engine only through `push_free`, the number of empty FIFO slots. The engine never raises `push_valid` when that count is zero. It starts a header pair only when two slots are free, and it starts a filler run only when the whole run fits. The FIFO storage and the receiving engine lie outside this block.

Top module: `chain_tx_dma`

## Requirements
- R1: During and right after reset, `busy`, `irq`, `overrun`, `rd_valid` and `push_valid` are all low.
- R2: A `start` pulse seen while idle latches `tag_base` as P and raises `busy` on the next cycle. Descriptor words 0..3 are read from P, P+4, P+8 and P+12, and the following descriptor of the chain is read from P+16.
- R3: The first two pushes of each descriptor are its word 2 and then its word 3, taken unchanged. Word 2 is not even requested from memory until `push_free` is at least 2.
- R4: The payload byte address is bits 23:0 of word 0; bits 29:24 are ignored. The payload length in words is bits 19:0 of word 1. Payload words are read from consecutive word addresses, starting at that address, and pushed in that order right after the header pair.
- R5: When any of bits 31:20 of word 1 is set, `overrun` pulses high for exactly one cycle, and the length is still taken from bits 19:0 alone.
- R6: `push_valid` is never high while `push_free` is 0. At most one word is pushed per cycle, and a payload word is requested only when at least one slot is free.
- R7: After the payload, (4 − length mod 4) mod 4 words of value 0 are pushed. This run starts only when `push_free` is at least its full length, and its words then go out on consecutive cycles.
- R8: When bit 31 (interrupt request) or bit 30 (stop) of word 0 is set, the chain ends after that descriptor's payload and filler. When both are clear, the next descriptor is fetched.
- R9: Let D be the total payload words pushed since `start`, with a floor of 1. `irq` rises exactly D clock edges after the edge that commits the final push, stays high for one cycle, and `busy` falls on that same edge.
- R10: A `start` pulse while `busy` is high is ignored: the pushed stream and the interrupt count are unchanged.
- R11: While `rd_ready` is low, `rd_valid` stays high and `rd_addr` is stable. A stalled memory changes only the timing, not the pushed stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin walking the chain at `tag_base` (honoured only when idle) |
| tag_base | input | 32 | Byte address of the first descriptor |
| busy | output | 1 | High from the cycle after an accepted start until the interrupt |
| irq | output | 1 | One-cycle completion pulse |
| overrun | output | 1 | One-cycle pulse when a length word has bits above bit 19 set |
| rd_valid | output | 1 | Memory read request valid |
| rd_ready | input | 1 | Memory accepts the request; `rd_data` is valid in this cycle |
| rd_addr | output | 32 | Memory byte address of the requested word |
| rd_data | input | 32 | Word returned for `rd_addr` |
| push_valid | output | 1 | A word is written into the FIFO this cycle |
| push_data | output | 32 | Word written into the FIFO |
| push_free | input | 6 | Number of empty FIFO slots |

## Verification
On every cycle, the bound checker covers these rules: the FIFO is never written while full, and the memory request stays steady under stall. It also checks that `irq` is a single-cycle pulse that coincides with `busy` falling, that `overrun` is a lone pulse inside a busy period, and that an idle engine drives no request. Other behaviour shows only in the directed scenarios, which build the expected word stream from the descriptor contents. These cover the exact word order and filler count, masking of the address and length fields, and chain termination on either flag bit. They also measure the interrupt delay against the payload total, check that a filler run waits until it fits, and confirm that a second start during a transfer is ignored.

// File: rtl/chain_tx_pkg.sv
package chain_tx_pkg;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned DESC_BYTES = 16;
  localparam int unsigned WORD_BYTES = 4;

  typedef enum logic [2:0] {
    S_IDLE,
    S_TAG0,   // fetch address/flags word
    S_TAG1,   // fetch length word
    S_TAG2,   // fetch + forward header word A
    S_TAG3,   // fetch + forward header word B
    S_DATA,   // stream payload
    S_PAD,    // zero filler to 16-byte group
    S_WAIT    // completion delay
  } tx_state_e;

endpackage

// File: rtl/chain_tx_tag_fields.sv
module chain_tx_tag_fields
  import chain_tx_pkg::*;
#(
  parameter int unsigned SRC_BITS = 24,
  parameter int unsigned CNT_BITS = 20
) (
  input  logic [WORD_W-1:0]   word,
  output logic [SRC_BITS-1:0] src_addr,
  output logic                stop,
  output logic [CNT_BITS-1:0] count,
  output logic [1:0]          junk,
  output logic                overrun
);

  // Interpretation as word 0: payload address and the two end flags.
  assign src_addr = word[SRC_BITS-1:0];
  assign stop     = word[WORD_W-1] | word[WORD_W-2];

  // Interpretation as word 1: payload length, filler length, overrun.
  assign count    = word[CNT_BITS-1:0];
  assign junk     = 2'(~word[1:0] + 2'd1);
  assign overrun  = |word[WORD_W-1:CNT_BITS];

endmodule

// File: rtl/chain_tx_irq_timer.sv
module chain_tx_irq_timer #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expiring,
  output logic         fire
);

  logic [W-1:0] remain;

  assign expiring = (remain == W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
      fire   <= 1'b0;
    end else begin
      fire <= expiring && !load;
      if (load)
        remain <= load_val;
      else if (remain != '0)
        remain <= remain - W'(1);
    end
  end

endmodule

// File: rtl/chain_tx_dma.sv
module chain_tx_dma
  import chain_tx_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 32,
  parameter int unsigned SRC_BITS   = 24,
  parameter int unsigned CNT_BITS   = 20,
  parameter int unsigned MOVED_W    = 24,
  parameter int unsigned FREE_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       tag_base,
  output logic              busy,
  output logic              irq,
  output logic              overrun,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [31:0]       rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic              push_valid,
  output logic [WORD_W-1:0] push_data,
  input  logic [FREE_W-1:0] push_free
);

  localparam logic [31:0] STEP_DESC = 32'(DESC_BYTES);
  localparam logic [31:0] STEP_WORD = 32'(WORD_BYTES);

  tx_state_e           state, state_d, after_block;
  logic [31:0]         tptr;
  logic [SRC_BITS-1:0] src;
  logic [CNT_BITS-1:0] cnt;
  logic [1:0]          jleft;
  logic                stop_q, pad_go, over_q;
  logic [MOVED_W-1:0]  moved, moved_nx, delay_val;

  logic [SRC_BITS-1:0] f_src;
  logic                f_stop, f_over;
  logic [CNT_BITS-1:0] f_cnt;
  logic [1:0]          f_junk;

  logic room1, room2, room_j, hs, fwd, pad_push, data_push;
  logic tmr_load, tmr_expiring, tmr_fire;

  chain_tx_tag_fields #(
    .SRC_BITS (SRC_BITS),
    .CNT_BITS (CNT_BITS)
  ) u_fields (
    .word     (rd_data),
    .src_addr (f_src),
    .stop     (f_stop),
    .count    (f_cnt),
    .junk     (f_junk),
    .overrun  (f_over)
  );

  assign room1  = (push_free != '0);
  assign room2  = (push_free >= FREE_W'(2));
  assign room_j = (push_free >= {{(FREE_W-2){1'b0}}, jleft});

  // Memory request
  always_comb begin
    rd_valid = 1'b0;
    rd_addr  = tptr;
    unique case (state)
      S_TAG0: rd_valid = 1'b1;
      S_TAG1: begin rd_valid = 1'b1;  rd_addr = tptr + STEP_WORD;          end
      S_TAG2: begin rd_valid = room2; rd_addr = tptr + 32'(2*WORD_BYTES);  end
      S_TAG3: begin rd_valid = room1; rd_addr = tptr + 32'(3*WORD_BYTES);  end
      S_DATA: begin rd_valid = room1; rd_addr = {{(32-SRC_BITS){1'b0}}, src}; end
      default: ;
    endcase
  end

  assign hs        = rd_valid && rd_ready;
  assign fwd       = hs && (state == S_TAG2 || state == S_TAG3 || state == S_DATA);
  assign pad_push  = (state == S_PAD) && (pad_go || room_j);
  assign data_push = (state == S_DATA) && hs;

  assign push_valid = fwd || pad_push;
  assign push_data  = pad_push ? '0 : rd_data;

  assign moved_nx  = (data_push && moved != '1) ? moved + MOVED_W'(1) : moved;
  assign delay_val = (moved_nx == '0) ? MOVED_W'(1) : moved_nx;

  assign after_block = stop_q ? S_WAIT : S_TAG0;

  always_comb begin
    state_d = state;
    unique case (state)
      S_IDLE: if (start) state_d = S_TAG0;
      S_TAG0: if (hs) state_d = S_TAG1;
      S_TAG1: if (hs) state_d = S_TAG2;
      S_TAG2: if (hs) state_d = S_TAG3;
      S_TAG3: if (hs) state_d = (cnt == '0) ? after_block : S_DATA;
      S_DATA: if (hs && cnt == CNT_BITS'(1))
                state_d = (jleft != 2'd0) ? S_PAD : after_block;
      S_PAD:  if (pad_push && jleft == 2'd1) state_d = after_block;
      S_WAIT: if (tmr_expiring) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  assign tmr_load = (state_d == S_WAIT) && (state != S_WAIT);

  chain_tx_irq_timer #(.W(MOVED_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (delay_val),
    .expiring (tmr_expiring),
    .fire     (tmr_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      tptr   <= '0;
      src    <= '0;
      cnt    <= '0;
      jleft  <= '0;
      stop_q <= 1'b0;
      pad_go <= 1'b0;
      over_q <= 1'b0;
      moved  <= '0;
    end else begin
      state  <= state_d;
      over_q <= 1'b0;
      moved  <= moved_nx;
      unique case (state)
        S_IDLE: if (start) begin
          tptr  <= tag_base;
          moved <= '0;
        end
        S_TAG0: if (hs) begin
          src    <= f_src;
          stop_q <= f_stop;
        end
        S_TAG1: if (hs) begin
          cnt    <= f_cnt;
          jleft  <= f_junk;
          over_q <= f_over;
        end
        S_TAG3: if (hs) tptr <= tptr + STEP_DESC;
        S_DATA: if (hs) begin
          src <= src + SRC_BITS'(WORD_BYTES);
          cnt <= cnt - CNT_BITS'(1);
        end
        S_PAD: if (pad_push) begin
          jleft  <= jleft - 2'd1;
          pad_go <= (jleft != 2'd1);
        end
        default: ;
      endcase
    end
  end

  assign busy    = (state != S_IDLE);
  assign irq     = tmr_fire;
  assign overrun = over_q;

endmodule

// File: rtl/chain_tx_dma_chk.sv
module chain_tx_dma_chk #(
  parameter int unsigned FREE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              irq,
  input logic              overrun,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [31:0]       rd_addr,
  input logic              push_valid,
  input logic [FREE_W-1:0] push_free
);

  a_r1_idle_no_traffic: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_valid && !push_valid));

  a_r2_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  a_r5_overrun_single: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> (busy ##1 !overrun));

  a_r6_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> (push_free != '0));

  a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r9_busy_falls_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);

  a_r9_irq_only_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);

  a_r11_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

endmodule

bind chain_tx_dma chain_tx_dma_chk #(.FREE_W(FREE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .irq        (irq),
  .overrun    (overrun),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_addr    (rd_addr),
  .push_valid (push_valid),
  .push_free  (push_free)
);

// File: tb/sim_chain_tx_dma.sv
`timescale 1ns/1ps
module sim_chain_tx_dma;

  localparam int DEPTH  = 32;
  localparam int FREE_W = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [31:0]       tag_base = '0;
  logic              busy, irq, overrun, rd_valid, push_valid;
  logic              rd_ready = 1'b1;
  logic [31:0]       rd_addr, rd_data, push_data;
  logic [FREE_W-1:0] push_free = FREE_W'(DEPTH);

  always #5 clk = ~clk;

  chain_tx_dma u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .tag_base(tag_base),
    .busy(busy), .irq(irq), .overrun(overrun),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data),
    .push_valid(push_valid), .push_data(push_data), .push_free(push_free)
  );

  logic [31:0] mem [0:255];
  assign rd_data = mem[rd_addr[9:2]];

  int total = 0, bad = 0;
  int cyc = 0, occ = 0, irq_n = 0, irq_t = 0, ovr_n = 0;
  bit pend = 0, drain_en = 1, stall_en = 0, ovf = 0, irq_busy = 0;
  logic [31:0] log_d[$];
  int          log_t[$];
  int          log_f[$];
  logic [31:0] exp_d[$];
  int          exp_words;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Output sampling, away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (push_valid) begin
      log_d.push_back(push_data);
      log_t.push_back(cyc);
      log_f.push_back(int'(push_free));
    end
    if (irq) begin irq_n++; irq_t = cyc; irq_busy = busy; end
    if (overrun) ovr_n++;
    pend = push_valid;
  end

  // FIFO occupancy and memory stall model, updated just after the edge.
  always @(posedge clk) begin
    #1;
    if (pend) occ++;
    if (drain_en && occ > 0) occ--;
    if (occ > DEPTH) ovf = 1;
    push_free = FREE_W'(DEPTH - occ);
    rd_ready  = stall_en ? ((cyc % 3) != 0) : 1'b1;
  end

  task automatic set_tag(input int ta, input logic [31:0] w0, w1, w2, w3);
    mem[ta>>2] = w0; mem[(ta>>2)+1] = w1; mem[(ta>>2)+2] = w2; mem[(ta>>2)+3] = w3;
  endtask

  task automatic add_block(input int ta, output bit stp);
    logic [31:0] w0, w1;
    int n, a, j;
    w0 = mem[ta>>2];
    w1 = mem[(ta>>2)+1];
    exp_d.push_back(mem[(ta>>2)+2]);
    exp_d.push_back(mem[(ta>>2)+3]);
    n = int'(w1[19:0]);
    a = int'(w0[23:0]);
    for (int i = 0; i < n; i++) exp_d.push_back(mem[((a>>2)+i) & 255]);
    j = (4 - (n % 4)) % 4;
    for (int i = 0; i < j; i++) exp_d.push_back(32'h0);
    exp_words += n;
    stp = w0[31] | w0[30];
  endtask

  task automatic build_expect(input int base);
    bit stp;
    int ta, guard;
    exp_d.delete(); exp_words = 0; ta = base; guard = 0; stp = 0;
    while (!stp && guard < 8) begin add_block(ta, stp); ta += 16; guard++; end
  endtask

  task automatic clear_log();
    log_d.delete(); log_t.delete(); log_f.delete();
    irq_n = 0; ovr_n = 0;
  endtask

  task automatic pulse_start(input int base);
    @(negedge clk); #1; tag_base = 32'(base); start = 1'b1;
    @(negedge clk); #1; start = 1'b0;
  endtask

  task automatic wait_irq(input string req, input bit poke);
    bit got;
    got = 0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk); #1;
      if (poke && k == 3) begin tag_base = 32'h0; start = 1'b1; end
      if (poke && k == 4) start = 1'b0;
      if (irq_n > 0) begin got = 1; break; end
    end
    chk(got, req, "interrupt never arrived", 0, 1);
    repeat (6) @(negedge clk);
    #1;
  endtask

  task automatic check_stream(input string req, input int ovr_exp);
    int d;
    chk(log_d.size() == exp_d.size(), req, "pushed word count", log_d.size(), exp_d.size());
    for (int i = 0; i < exp_d.size() && i < log_d.size(); i++)
      chk(log_d[i] == exp_d[i], req, $sformatf("pushed word %0d", i), log_d[i], exp_d[i]);
    chk(irq_n == 1, "R9", "interrupt pulses", irq_n, 1);
    chk(!irq_busy, "R9", "busy at interrupt", irq_busy, 0);
    d = (exp_words == 0) ? 1 : exp_words;
    if (log_t.size() > 0)
      chk(irq_t - log_t[log_t.size()-1] == d + 1, "R9", "interrupt delay after last push",
          irq_t - log_t[log_t.size()-1], d + 1);
    chk(ovr_n == ovr_exp, "R5", "overrun pulses", ovr_n, ovr_exp);
  endtask

  task automatic run_chain(input int base, input string req, input bit poke, input int ovr_exp);
    build_expect(base);
    clear_log();
    pulse_start(base);
    wait_irq(req, poke);
    check_stream(req, ovr_exp);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !irq && !overrun, "R1", "status after reset", {busy, irq, overrun}, 0);
    chk(!rd_valid && !push_valid, "R1", "traffic after reset", {rd_valid, push_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(!busy && !rd_valid && !push_valid, "R1", "idle after release", {busy, rd_valid, push_valid}, 0);
  endtask

  // R3, R4, R7: one descriptor, five payload words, three fillers.
  task automatic t_single();
    run_chain(32'h00, "R3/R4/R7", 0, 0);
  endtask

  // R2, R8, R10: two-descriptor chain, start poked mid-transfer.
  task automatic t_chain();
    run_chain(32'h10, "R2/R8/R10", 1, 0);
    repeat (10) @(negedge clk);
    #1;
    chk(!busy && irq_n == 1, "R10", "no restart after ignored start", {busy, 8'(irq_n)}, 1);
  endtask

  // R4, R5: upper address bits and oversize length.
  task automatic t_overrun();
    run_chain(32'h30, "R4/R5", 0, 1);
  endtask

  // R9: zero-length terminal descriptor, minimum delay.
  task automatic t_empty();
    run_chain(32'h40, "R9", 0, 0);
  endtask

  // R3, R7: header waits for two slots, filler waits for the whole run.
  task automatic t_backpressure();
    build_expect(32'h60);
    clear_log();
    @(negedge clk); #1; drain_en = 0; occ = 31;
    repeat (2) @(negedge clk);
    pulse_start(32'h60);
    repeat (10) @(negedge clk);
    #1;
    chk(log_d.size() == 0, "R3", "header pushed with one free slot", log_d.size(), 0);
    occ = 29;
    repeat (12) @(negedge clk);
    #1;
    chk(log_d.size() == 3, "R7", "filler started before it fits", log_d.size(), 3);
    drain_en = 1;
    wait_irq("R7", 0);
    check_stream("R3/R7", 0);
    if (log_f.size() == 6) begin
      chk(log_f[3] >= 3, "R7", "free slots at first filler", log_f[3], 3);
      chk(log_t[4] == log_t[3] + 1 && log_t[5] == log_t[4] + 1, "R7",
          "filler cycles consecutive", log_t[5] - log_t[3], 2);
    end
    repeat (40) @(negedge clk);
  endtask

  // R11: the chain from t_chain under a stalling memory.
  task automatic t_stall();
    stall_en = 1;
    run_chain(32'h10, "R11", 0, 0);
    stall_en = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hD000_0000 + 32'(i);
    set_tag(32'h00, 32'h8000_0100, 32'd5,         32'h7A7A_0001, 32'h7A7A_0002);
    set_tag(32'h10, 32'h0000_0140, 32'd4,         32'h6B6B_0001, 32'h6B6B_0002);
    set_tag(32'h20, 32'h4000_0180, 32'd2,         32'h6B6B_0003, 32'h6B6B_0004);
    set_tag(32'h30, 32'hC500_01C0, 32'hABC0_0003, 32'h5C5C_0001, 32'h5C5C_0002);
    set_tag(32'h40, 32'h8000_0000, 32'd0,         32'h4D4D_0001, 32'h4D4D_0002);
    set_tag(32'h60, 32'h8000_0300, 32'd1,         32'h3E3E_0001, 32'h3E3E_0002);
    t_reset();
    t_single();
    t_chain();
    t_overrun();
    t_empty();
    t_backpressure();
    t_stall();
    chk(!ovf, "R6", "FIFO model overflowed", ovf, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL all watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule